// File: doc/BRIEF.md
# Priority memory permission checker

This block decides whether one memory access may go ahead. A requester offers an access start address, a byte count, the read/write/execute bits it needs and whether it runs in machine mode. The block captures that request in a register and, one cycle later, presents a grant bit and the mask of rights the governing rule allows. The rules come from a table of protection entries. Each entry is an inclusive address range, already decoded into a low and a high bound, plus one configuration byte. Three security flags change the rule set: a lockdown flag, a whitelist-default flag and a lock-bypass flag.

Entries are scanned from index 0 upward. The first active entry that the access touches decides the result. If that entry holds only one end of the access, the access is refused. Without lockdown, the entry's own RWX bits apply, and machine mode is exempt unless the entry is locked. With lockdown, a 16-row table indexed by the entry's lock and RWX bits gives the rights, and machine mode and lower modes use different tables. When no entry is touched, a default chain applies.

The control is a two-state machine. In `ST_IDLE` the block is ready. The transition ACCEPT (valid while ready) captures the request and moves to `ST_RESP`. `ST_RESP` shows the response for exactly one cycle. The transition RETIRE always returns to `ST_IDLE`. The entry table and the flags are read live and must hold steady while a request is in flight.

Top module: `pmp_perm_checker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 during the following cycle only, and `req_ready` is 0 during that cycle.
- R2: While `rsp_valid` is 0, `rsp_grant` and `rsp_allow` are 0.
- R3: Configuration byte layout: bit 0 is R, bit 1 is W, bit 2 is X, bits 4:3 are the match field (nonzero means the entry is active), and bit 7 is the lock bit L. The first active entry with the lowest index that contains the first byte or the last byte of the access decides the result. Inactive entries are skipped.
- R4: The first byte is the address. The last byte is address + size - 1, modulo 2^AW. A size of 0 counts as 4 bytes. An entry contains byte b when low <= b <= high.
- R5: If the deciding entry contains exactly one of the two end bytes, `rsp_allow` is 0 and `rsp_grant` is 0.
- R6: With lockdown clear, the deciding entry gives RWX (7) to machine mode when the entry is not locked. Otherwise it gives the entry's RWX bits. An entry counts as locked when L is 1 and the lock-bypass flag is 0.
- R7: With lockdown set, machine mode takes its rights from index {L,R,W,X}, where L is the most significant bit: 2, 3 and 14 give RW; 9 and 10 give X; 11 and 13 give RX; 12 and 15 give R; all other indices give nothing. The lock-bypass flag has no effect here.
- R8: With lockdown set, lower modes take their rights from the same index: 1, 10 and 11 give X; 2, 4 and 15 give R; 3 and 6 give RW; 5 gives RX; 7 gives RWX; all other indices give nothing.
- R9: When no entry decides, the default chain applies. With the whitelist flag set, the mask is 0. Otherwise, with lockdown set, machine mode gets RW (3) and lower modes get 0. Otherwise machine mode gets RWX (7) and lower modes get 0.
- R10: Request and mask bits share one encoding: bit 0 is R, bit 1 is W, bit 2 is X. Apart from the R5 case, `rsp_grant` is 1 exactly when every requested bit is also set in `rsp_allow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | First byte address |
| req_size | input | SZW | Byte count, 0 means 4 |
| req_rwx | input | 3 | Requested rights, bit 0 R, bit 1 W, bit 2 X |
| req_mmode | input | 1 | 1 for machine mode, 0 for lower modes |
| ent_lo | input | NENT*AW | Low bounds, entry i at bits [i*AW +: AW] |
| ent_hi | input | NENT*AW | High bounds, same packing |
| ent_cfg | input | NENT*8 | Configuration bytes, entry i at bits [i*8 +: 8] |
| sec_lockdown | input | 1 | Lockdown rule set enable |
| sec_whitelist | input | 1 | Deny-all default when nothing matches |
| sec_unlock | input | 1 | Lock bypass for the classic rules |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access permitted |
| rsp_allow | output | 3 | Allowed rights mask |

## Verification
The bench builds the block with four entries, 16-bit addresses and a 4-bit size. That keeps every range small enough to place by hand. With four entries the bench can stack overlapping ranges and test priority between a narrow and a wide entry. It can also turn one entry off and watch the next one take over. A sweep of all 16 {L,R,W,X} indices in both modes, with each single requested right, covers both lockdown tables completely. Accesses that straddle an entry edge, including a size-0 access, reach the partial-overlap rule and the size rule.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } chk_state_e;

    localparam int CFG_R   = 0;
    localparam int CFG_W   = 1;
    localparam int CFG_X   = 2;
    localparam int CFG_AMO = 3;
    localparam int CFG_L   = 7;

    localparam logic [2:0] RIGHT_NONE = 3'b000;
    localparam logic [2:0] RIGHT_R    = 3'b001;
    localparam logic [2:0] RIGHT_RW   = 3'b011;
    localparam logic [2:0] RIGHT_X    = 3'b100;
    localparam logic [2:0] RIGHT_RX   = 3'b101;
    localparam logic [2:0] RIGHT_RWX  = 3'b111;

    // Lockdown rights for machine mode, index is {L,R,W,X}
    function automatic logic [2:0] lockdown_mach(input logic [3:0] idx);
        logic [2:0] r;
        unique case (idx)
            4'd2, 4'd3, 4'd14: r = RIGHT_RW;
            4'd9, 4'd10:       r = RIGHT_X;
            4'd11, 4'd13:      r = RIGHT_RX;
            4'd12, 4'd15:      r = RIGHT_R;
            default:           r = RIGHT_NONE;
        endcase
        return r;
    endfunction

    // Lockdown rights for lower modes, index is {L,R,W,X}
    function automatic logic [2:0] lockdown_user(input logic [3:0] idx);
        logic [2:0] r;
        unique case (idx)
            4'd1, 4'd10, 4'd11: r = RIGHT_X;
            4'd2, 4'd4, 4'd15:  r = RIGHT_R;
            4'd3, 4'd6:         r = RIGHT_RW;
            4'd5:               r = RIGHT_RX;
            4'd7:               r = RIGHT_RWX;
            default:            r = RIGHT_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pmp_span_calc.sv
module pmp_span_calc #(
    parameter int AW  = 32,
    parameter int SZW = 4
) (
    input  logic [AW-1:0]  addr,
    input  logic [SZW-1:0] size,
    output logic [AW-1:0]  first_b,
    output logic [AW-1:0]  last_b
);
    localparam logic [SZW-1:0] SIZE_DFLT = SZW'(4);

    logic [SZW-1:0] eff_size;

    always_comb begin
        eff_size = (size == '0) ? SIZE_DFLT : size;
        first_b  = addr;
        last_b   = addr + AW'(eff_size) - AW'(1);
    end
endmodule

// File: rtl/pmp_entry_cmp.sv
module pmp_entry_cmp #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [1:0]    amode,
    input  logic [AW-1:0] first_b,
    input  logic [AW-1:0] last_b,
    output logic          full_hit,
    output logic          part_hit
);
    logic active;
    logic in_first;
    logic in_last;

    always_comb begin
        active   = (amode != 2'b00);
        in_first = (first_b >= lo) && (first_b <= hi);
        in_last  = (last_b  >= lo) && (last_b  <= hi);
        full_hit = active && in_first && in_last;
        part_hit = active && (in_first ^ in_last);
    end
endmodule

// File: rtl/pmp_first_pick.sv
module pmp_first_pick #(
    parameter int NENT = 8,
    localparam int IDXW = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic [NENT-1:0] full_hit,
    input  logic [NENT-1:0] part_hit,
    output logic            found,
    output logic            is_part,
    output logic [IDXW-1:0] win_idx
);
    always_comb begin
        found   = 1'b0;
        is_part = 1'b0;
        win_idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (full_hit[i] || part_hit[i]) begin
                found   = 1'b1;
                is_part = part_hit[i];
                win_idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
    import pmp_chk_pkg::*;
(
    input  logic [7:0] cfg,
    input  logic       found,
    input  logic       is_part,
    input  logic       mmode,
    input  logic [2:0] want,
    input  logic       lockdown,
    input  logic       whitelist,
    input  logic       unlock,
    output logic [2:0] allow,
    output logic       grant
);
    logic [3:0] tab_idx;
    logic       locked;
    logic       refuse;

    always_comb begin
        tab_idx = {cfg[CFG_L], cfg[CFG_R], cfg[CFG_W], cfg[CFG_X]};
        locked  = cfg[CFG_L] && !unlock;
        refuse  = 1'b0;
        allow   = RIGHT_NONE;
        if (found && is_part) begin
            refuse = 1'b1;
        end else if (found) begin
            if (lockdown) begin
                allow = mmode ? lockdown_mach(tab_idx) : lockdown_user(tab_idx);
            end else if (mmode && !locked) begin
                allow = RIGHT_RWX;
            end else begin
                allow = cfg[2:0];
            end
        end else if (whitelist) begin
            allow = RIGHT_NONE;
        end else if (lockdown) begin
            allow = mmode ? RIGHT_RW : RIGHT_NONE;
        end else begin
            allow = mmode ? RIGHT_RWX : RIGHT_NONE;
        end
        grant = !refuse && ((want & ~allow) == 3'b000);
    end
endmodule

// File: rtl/pmp_perm_checker.sv
module pmp_perm_checker
    import pmp_chk_pkg::*;
#(
    parameter int NENT = 8,
    parameter int AW   = 32,
    parameter int SZW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-1:0]      req_addr,
    input  logic [SZW-1:0]     req_size,
    input  logic [2:0]         req_rwx,
    input  logic               req_mmode,
    input  logic [NENT*AW-1:0] ent_lo,
    input  logic [NENT*AW-1:0] ent_hi,
    input  logic [NENT*8-1:0]  ent_cfg,
    input  logic               sec_lockdown,
    input  logic               sec_whitelist,
    input  logic               sec_unlock,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic [2:0]         rsp_allow
);
    localparam int IDXW = (NENT > 1) ? $clog2(NENT) : 1;

    chk_state_e     state_q, state_d;
    logic [AW-1:0]  cap_addr;
    logic [SZW-1:0] cap_size;
    logic [2:0]     cap_rwx;
    logic           cap_mmode;

    logic [AW-1:0]   first_b, last_b;
    logic [NENT-1:0] full_hit, part_hit;
    logic [7:0]      cfg_arr [NENT];
    logic            found, is_part;
    logic [IDXW-1:0] win_idx;
    logic [2:0]      allow_w;
    logic            grant_w;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture on ACCEPT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_size  <= '0;
            cap_rwx   <= '0;
            cap_mmode <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            cap_addr  <= req_addr;
            cap_size  <= req_size;
            cap_rwx   <= req_rwx;
            cap_mmode <= req_mmode;
        end
    end

    // Transitions: ACCEPT, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_grant = 1'b0;
        rsp_allow = 3'b000;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_grant = grant_w;
                rsp_allow = allow_w;
            end
        endcase
    end

    pmp_span_calc #(.AW(AW), .SZW(SZW)) u_span (
        .addr    (cap_addr),
        .size    (cap_size),
        .first_b (first_b),
        .last_b  (last_b)
    );

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        assign cfg_arr[g] = ent_cfg[g*8 +: 8];
        pmp_entry_cmp #(.AW(AW)) u_cmp (
            .lo       (ent_lo[g*AW +: AW]),
            .hi       (ent_hi[g*AW +: AW]),
            .amode    (ent_cfg[g*8+CFG_AMO +: 2]),
            .first_b  (first_b),
            .last_b   (last_b),
            .full_hit (full_hit[g]),
            .part_hit (part_hit[g])
        );
    end

    pmp_first_pick #(.NENT(NENT)) u_pick (
        .full_hit (full_hit),
        .part_hit (part_hit),
        .found    (found),
        .is_part  (is_part),
        .win_idx  (win_idx)
    );

    pmp_perm_eval u_eval (
        .cfg       (cfg_arr[win_idx]),
        .found     (found),
        .is_part   (is_part),
        .mmode     (cap_mmode),
        .want      (cap_rwx),
        .lockdown  (sec_lockdown),
        .whitelist (sec_whitelist),
        .unlock    (sec_unlock),
        .allow     (allow_w),
        .grant     (grant_w)
    );
endmodule

// File: rtl/pmp_perm_checker_sva.sv
module pmp_perm_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_rwx,
    input logic       req_mmode,
    input logic       sec_lockdown,
    input logic       rsp_valid,
    input logic       rsp_grant,
    input logic [2:0] rsp_allow
);
    a_r1_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r1_resp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && rsp_allow == 3'b000));

    a_r10_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> (($past(req_rwx) & ~rsp_allow) == 3'b000));

    a_r7_mach_never_rwx: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && sec_lockdown && $past(req_mmode)) |-> (rsp_allow != 3'b111));
endmodule

bind pmp_perm_checker pmp_perm_checker_sva u_sva (.*);

// File: tb/pmp_perm_checker_test.sv
module pmp_perm_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NENT = 4;
    localparam int AW   = 16;
    localparam int SZW  = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [AW-1:0]      req_addr = '0;
    logic [SZW-1:0]     req_size = '0;
    logic [2:0]         req_rwx = '0;
    logic               req_mmode = 1'b0;
    logic [NENT*AW-1:0] ent_lo = '0;
    logic [NENT*AW-1:0] ent_hi = '0;
    logic [NENT*8-1:0]  ent_cfg = '0;
    logic               sec_lockdown = 1'b0;
    logic               sec_whitelist = 1'b0;
    logic               sec_unlock = 1'b0;
    logic               rsp_valid;
    logic               rsp_grant;
    logic [2:0]         rsp_allow;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    string cur_tag = "R1";

    int lo_a [NENT];
    int hi_a [NENT];
    int cfg_a [NENT];
    int mt [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
    int lt [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

    bit m_busy = 1'b0;
    int m_addr, m_size, m_rwx;
    bit m_mm;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmp_perm_checker #(.NENT(NENT), .AW(AW), .SZW(SZW)) uut (.*);

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(output int allow, output bit grant);
        int eff, last, am;
        bit fi, li, decided;
        eff = (m_size == 0) ? 4 : m_size;
        last = (m_addr + eff - 1) & ((1 << AW) - 1);
        decided = 1'b0;
        allow = 0;
        grant = 1'b0;
        for (int e = 0; e < NENT; e++) begin
            am = (cfg_a[e] >> 3) & 3;
            fi = (m_addr >= lo_a[e]) && (m_addr <= hi_a[e]);
            li = (last >= lo_a[e]) && (last <= hi_a[e]);
            if (!decided && am != 0 && (fi || li)) begin
                decided = 1'b1;
                if (fi != li) begin
                    allow = 0;
                    grant = 1'b0;
                    return;
                end
                if (sec_lockdown) begin
                    int ix = (((cfg_a[e] >> 7) & 1) << 3) | ((cfg_a[e] & 1) << 2)
                           | (((cfg_a[e] >> 1) & 1) << 1) | ((cfg_a[e] >> 2) & 1);
                    allow = m_mm ? mt[ix] : lt[ix];
                end else if (m_mm && !(((cfg_a[e] >> 7) & 1) == 1 && !sec_unlock)) begin
                    allow = 7;
                end else begin
                    allow = cfg_a[e] & 7;
                end
            end
        end
        if (!decided) begin
            if (sec_whitelist)     allow = 0;
            else if (sec_lockdown) allow = m_mm ? 3 : 0;
            else                   allow = m_mm ? 7 : 0;
        end
        grant = ((m_rwx & ~allow & 7) == 0);
    endtask

    // Reference model updated at the edge, compared a quarter period later
    always @(posedge clk) begin
        int ea;
        bit eg;
        cyc++;
        if (!rst_n) m_busy = 1'b0;
        else if (m_busy) m_busy = 1'b0;
        else if (req_valid) begin
            m_busy = 1'b1;
            m_addr = int'(req_addr);
            m_size = int'(req_size);
            m_rwx  = int'(req_rwx);
            m_mm   = req_mmode;
        end
        #(CLK_PERIOD/4);
        check("R1", "ready", int'(req_ready), int'(!m_busy));
        check("R1", "rsp_valid", int'(rsp_valid), int'(m_busy));
        if (m_busy) begin
            model(ea, eg);
            check(cur_tag, "allow", int'(rsp_allow), ea);
            check(cur_tag, "grant", int'(rsp_grant), int'(eg));
        end else begin
            check("R2", "idle allow", int'(rsp_allow), 0);
            check("R2", "idle grant", int'(rsp_grant), 0);
        end
        if (cyc == 100000) begin
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic set_ent(int i, int lo, int hi, int cfg);
        @(negedge clk);
        lo_a[i] = lo; hi_a[i] = hi; cfg_a[i] = cfg;
        ent_lo[i*AW +: AW] = AW'(lo);
        ent_hi[i*AW +: AW] = AW'(hi);
        ent_cfg[i*8 +: 8]  = 8'(cfg);
    endtask

    task automatic set_flags(bit ld, bit wl, bit ul);
        @(negedge clk);
        sec_lockdown = ld; sec_whitelist = wl; sec_unlock = ul;
    endtask

    task automatic req(int a, int sz, int rwx, bit mm, string tag);
        @(negedge clk);
        cur_tag   = tag;
        req_addr  = AW'(a);
        req_size  = SZW'(sz);
        req_rwx   = 3'(rwx);
        req_mmode = mm;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) begin
            lo_a[i] = 0; hi_a[i] = 0; cfg_a[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset ready", int'(req_ready), 1);
        check("R2", "reset rsp_valid", int'(rsp_valid), 0);

        // R9: no active entries
        req(16'h0040, 4, 7, 1'b1, "R9");
        req(16'h0040, 4, 1, 1'b0, "R9");
        set_flags(1'b0, 1'b1, 1'b0);
        req(16'h0040, 4, 1, 1'b1, "R9");
        set_flags(1'b1, 1'b0, 1'b0);
        req(16'h0040, 4, 3, 1'b1, "R9");
        req(16'h0040, 4, 4, 1'b1, "R9");
        req(16'h0040, 4, 1, 1'b0, "R9");
        set_flags(1'b0, 1'b0, 1'b0);

        // R6: classic rules, read-only entry
        set_ent(0, 16'h0100, 16'h01FF, 8'h19);
        req(16'h0120, 4, 1, 1'b0, "R6");
        req(16'h0120, 4, 2, 1'b0, "R6");
        req(16'h0120, 4, 2, 1'b1, "R6");
        set_ent(0, 16'h0100, 16'h01FF, 8'h99);
        req(16'h0120, 4, 2, 1'b1, "R6");
        set_flags(1'b0, 1'b0, 1'b1);
        req(16'h0120, 4, 2, 1'b1, "R6");
        set_flags(1'b0, 1'b0, 1'b0);

        // R3: priority between overlapping entries
        set_ent(0, 16'h0100, 16'h010F, 8'h19);
        set_ent(1, 16'h0100, 16'h01FF, 8'h1B);
        req(16'h0104, 4, 2, 1'b0, "R3");
        req(16'h0120, 4, 2, 1'b0, "R3");
        set_ent(0, 16'h0100, 16'h010F, 8'h01);
        req(16'h0104, 4, 2, 1'b0, "R3");
        set_ent(0, 16'h0100, 16'h010F, 8'h19);

        // R5 and R4: straddling accesses and size 0
        req(16'h01FE, 4, 1, 1'b1, "R5");
        req(16'h010E, 0, 1, 1'b0, "R4");
        req(16'h010E, 2, 1, 1'b0, "R4");
        req(16'h010C, 0, 1, 1'b0, "R4");
        req(16'h00FE, 3, 1, 1'b1, "R5");

        // R7 and R8: full lockdown tables
        set_ent(1, 0, 0, 0);
        set_flags(1'b1, 1'b0, 1'b1);
        for (int ix = 0; ix < 16; ix++) begin
            int c;
            c = ((ix >> 3) << 7) | 8'h18 | (((ix >> 2) & 1)) | (((ix >> 1) & 1) << 1)
              | ((ix & 1) << 2);
            set_ent(0, 16'h0200, 16'h02FF, c);
            for (int r = 0; r < 3; r++) begin
                req(16'h0210, 4, 1 << r, 1'b1, "R7");
                req(16'h0210, 4, 1 << r, 1'b0, "R8");
            end
        end
        set_flags(1'b0, 1'b0, 1'b0);

        // R10: multi-bit requests against a RW entry
        set_ent(0, 16'h0300, 16'h03FF, 8'h1B);
        req(16'h0300, 4, 3, 1'b0, "R10");
        req(16'h0300, 4, 7, 1'b0, "R10");
        req(16'h0300, 4, 0, 1'b0, "R10");

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule